// File: doc/BRIEF.md
# Synchronous Serial Transmit Idle Generator

This block drives the serial line of a synchronous transmitter while no frame is being sent. It repeats an idle pattern of either 8 or 16 bits. The low byte always comes from the idle byte input. For 16-bit idle, the high byte comes from the preamble byte input, which shares that storage. The pattern is shifted out least significant bit first, one bit per transmit bit-enable pulse.

When the framer signals that data is ready, the block completes the idle pattern it has started. It then passes the framer's bits straight to the line and acknowledges each bit it takes. A control word enables the transmitter, holds it in reset, enables the preamble and selects the idle size. While the transmitter is off or in reset, the line rests at mark.

Top module: `txidle_gen`

## Requirements
- R1: When control bit 1 (transmit enable) is 0, the line output is 1 on every cycle after the first clock edge and `data_take_o` stays 0.
- R2: When control bit 2 (transmit reset) is 1, the transmitter stops and the line output is 1, even if bit 1 is set. After reset is released, a fresh pattern starts with its bit 0.
- R3: With the preamble disabled (control bit 6 = 0) and size code 00 in control bits 5:4, the line repeats `idle_lo_i` LSB first with a period of 8 bit-enables. The standard patterns 0x7E, 0xAA, 0x00 and 0xFF appear unchanged on the line.
- R4: With the preamble disabled and size code 01, the line repeats a 16-bit pattern with a period of 16 bit-enables. The pattern is `idle_lo_i` LSB first, followed by `pre_hi_i` LSB first.
- R5: When control bit 6 (preamble enable) is 1, the idle size is 8 bits whatever the size code.
- R6: Size codes 10 and 11 give 8-bit idle.
- R7: A change to the idle bytes or to the size takes effect only at the next pattern boundary. A pattern already started is always sent in full.
- R8: If `data_ready_i` rises in the middle of a pattern, idle bits continue until the pattern ends, and `data_take_o` stays 0 meanwhile. From the boundary on, each bit-enable with `data_ready_i` high puts `data_bit_i` on the line and pulses `data_take_o` in that cycle. When data ready drops, a new idle pattern starts.
- R9: While the transmitter runs, the line output changes only in the cycle after a bit-enable pulse.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ctl_word_i | input | 16 | Control word: bit 1 enable, bit 2 reset, bits 5:4 size code, bit 6 preamble enable |
| idle_lo_i | input | 8 | Idle byte (low byte of the pattern) |
| pre_hi_i | input | 8 | Preamble byte (high byte of the 16-bit idle) |
| bit_en_i | input | 1 | Transmit bit-enable pulse |
| data_ready_i | input | 1 | Framer has a bit to send |
| data_bit_i | input | 1 | Framer bit |
| data_take_o | output | 1 | Framer bit consumed in this cycle |
| line_o | output | 1 | Serial line output |

## Verification
The assertions check on every cycle that:
- the line rests at mark while the transmitter is off;
- the line holds between bit-enables;
- the bit counter only steps down;
- handover to data never starts in the middle of a pattern;
- the preamble always forces the short pattern length.

Only the bench scenarios can show the actual bit sequences: the standard and 16-bit patterns in LSB-first order, and the deferred effect of a register change in the middle of a pattern. They also show the exact bit-enable on which framer data replaces idle, and that a fresh pattern starts after reset is released.

// File: rtl/txidle_pkg.sv
package txidle_pkg;
   typedef enum logic {
      MODE_IDLE = 1'b0,
      MODE_DATA = 1'b1
   } txi_mode_e;

   localparam logic [1:0] SIZE_CODE_8  = 2'b00;
   localparam logic [1:0] SIZE_CODE_16 = 2'b01;
endpackage

// File: rtl/txidle_pattern_sel.sv
module txidle_pattern_sel #(
   parameter int BYTE_W    = 8,
   parameter int CTRL_W    = 16,
   parameter int PRE_BIT   = 6,
   parameter int SIZE_LSB  = 4,
   parameter bit WIDE_IDLE = 1'b1,
   localparam int PAT_W    = 2 * BYTE_W,
   localparam int CNT_W    = $clog2(PAT_W)
) (
   input  logic [CTRL_W-1:0] ctl_i,
   input  logic [BYTE_W-1:0] lo_i,
   input  logic [BYTE_W-1:0] hi_i,
   output logic [PAT_W-1:0]  pat_o,
   output logic [CNT_W-1:0]  len_m1_o
);
   import txidle_pkg::*;

   logic wide;

   generate
      if (WIDE_IDLE) begin : g_wide
         assign wide = !ctl_i[PRE_BIT] && (ctl_i[SIZE_LSB +: 2] == SIZE_CODE_16);
      end else begin : g_narrow
         logic unused_sel;
         assign unused_sel = ^{ctl_i[PRE_BIT], ctl_i[SIZE_LSB +: 2]};
         assign wide = 1'b0;
      end
   endgenerate

   always_comb begin
      if (wide) begin
         pat_o    = {hi_i, lo_i};
         len_m1_o = CNT_W'(PAT_W - 1);
      end else begin
         pat_o    = {{BYTE_W{1'b0}}, lo_i};
         len_m1_o = CNT_W'(BYTE_W - 1);
      end
   end

   logic unused_ctl;
   assign unused_ctl = ^ctl_i;
endmodule

// File: rtl/txidle_shifter.sv
module txidle_shifter #(
   parameter int PAT_W = 16,
   localparam int CNT_W = $clog2(PAT_W)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run_i,
   input  logic             bit_en_i,
   input  logic [PAT_W-1:0] pat_i,
   input  logic [CNT_W-1:0] len_m1_i,
   input  logic             data_ready_i,
   input  logic             data_bit_i,
   output logic             take_o,
   output logic             line_o
);
   import txidle_pkg::*;

   logic [PAT_W-1:0] sh_q;
   logic [CNT_W-1:0] cnt_q;
   txi_mode_e        mode_q;
   logic             line_q;
   logic             boundary;

   assign boundary = (cnt_q == '0);
   assign take_o   = run_i && bit_en_i && boundary && data_ready_i;
   assign line_o   = line_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         line_q <= 1'b1;
         sh_q   <= '0;
         cnt_q  <= '0;
         mode_q <= MODE_IDLE;
      end else if (!run_i) begin
         line_q <= 1'b1;
         cnt_q  <= '0;
         mode_q <= MODE_IDLE;
      end else if (bit_en_i) begin
         if (boundary) begin
            if (data_ready_i) begin
               mode_q <= MODE_DATA;
               line_q <= data_bit_i;
            end else begin
               mode_q <= MODE_IDLE;
               line_q <= pat_i[0];
               sh_q   <= pat_i >> 1;
               cnt_q  <= len_m1_i;
            end
         end else begin
            line_q <= sh_q[0];
            sh_q   <= sh_q >> 1;
            cnt_q  <= cnt_q - 1'b1;
         end
      end
   end

   assert_mark_when_off_R1: assert property (@(posedge clk) disable iff (!rst_n)
      !run_i |=> line_o);

   assert_hold_between_en_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (run_i && !bit_en_i) |=> $stable(line_o));

   assert_count_steps_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (run_i && bit_en_i && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - 1'b1));

   assert_no_mid_handover_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (run_i && bit_en_i && cnt_q != '0) |=> (mode_q == MODE_IDLE));
endmodule

// File: rtl/txidle_gen.sv
module txidle_gen #(
   parameter int BYTE_W    = 8,
   parameter int CTRL_W    = 16,
   parameter int EN_BIT    = 1,
   parameter int RST_BIT   = 2,
   parameter int SIZE_LSB  = 4,
   parameter int PRE_BIT   = 6,
   parameter bit WIDE_IDLE = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [CTRL_W-1:0] ctl_word_i,
   input  logic [BYTE_W-1:0] idle_lo_i,
   input  logic [BYTE_W-1:0] pre_hi_i,
   input  logic              bit_en_i,
   input  logic              data_ready_i,
   input  logic              data_bit_i,
   output logic              data_take_o,
   output logic              line_o
);
   localparam int PAT_W = 2 * BYTE_W;
   localparam int CNT_W = $clog2(PAT_W);

   initial begin
      assert (BYTE_W >= 2);
      assert (EN_BIT < CTRL_W && RST_BIT < CTRL_W && PRE_BIT < CTRL_W);
      assert (SIZE_LSB + 1 < CTRL_W);
   end

   logic             run;
   logic [PAT_W-1:0] pat;
   logic [CNT_W-1:0] len_m1;

   assign run = ctl_word_i[EN_BIT] && !ctl_word_i[RST_BIT];

   txidle_pattern_sel #(
      .BYTE_W(BYTE_W), .CTRL_W(CTRL_W), .PRE_BIT(PRE_BIT),
      .SIZE_LSB(SIZE_LSB), .WIDE_IDLE(WIDE_IDLE)
   ) u_sel (
      .ctl_i(ctl_word_i), .lo_i(idle_lo_i), .hi_i(pre_hi_i),
      .pat_o(pat), .len_m1_o(len_m1)
   );

   txidle_shifter #(.PAT_W(PAT_W)) u_shift (
      .clk(clk), .rst_n(rst_n), .run_i(run), .bit_en_i(bit_en_i),
      .pat_i(pat), .len_m1_i(len_m1), .data_ready_i(data_ready_i),
      .data_bit_i(data_bit_i), .take_o(data_take_o), .line_o(line_o)
   );

   assert_preamble_short_R5: assert property (@(posedge clk) disable iff (!rst_n)
      ctl_word_i[PRE_BIT] |-> (len_m1 == CNT_W'(BYTE_W - 1)));
endmodule

// File: tb/txidle_gen_tb.sv
module txidle_gen_tb;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [15:0] ctl = '0;
   logic [7:0]  lo = '0;
   logic [7:0]  hi = '0;
   logic        bit_en = 1'b0;
   logic        drdy = 1'b0;
   logic        dbit = 1'b0;
   logic        take;
   logic        line;
   int          checks = 0;
   int          errors = 0;
   bit          done = 1'b0;

   always #4 clk = ~clk;

   txidle_gen u_dut (
      .clk(clk), .rst_n(rst_n), .ctl_word_i(ctl), .idle_lo_i(lo),
      .pre_hi_i(hi), .bit_en_i(bit_en), .data_ready_i(drdy),
      .data_bit_i(dbit), .data_take_o(take), .line_o(line)
   );

   typedef struct packed {
      logic [15:0] ctl;
      logic [7:0]  lo;
      logic [7:0]  hi;
      logic [31:0] exp;
      logic [7:0]  req;
   } vec_t;

   localparam vec_t VECS [8] = '{
      '{16'h0002, 8'h7E, 8'h00, 32'h7E7E7E7E, 8'd3}, // R3 flags
      '{16'h0002, 8'hAA, 8'h00, 32'hAAAAAAAA, 8'd3}, // R3 alternating
      '{16'h0002, 8'h00, 8'hFF, 32'h00000000, 8'd3}, // R3 zeros
      '{16'h0002, 8'hFF, 8'h00, 32'hFFFFFFFF, 8'd3}, // R3 ones
      '{16'h0012, 8'h3C, 8'hA5, 32'hA53CA53C, 8'd4}, // R4 16-bit
      '{16'h0052, 8'h3C, 8'hA5, 32'h3C3C3C3C, 8'd5}, // R5 preamble forces 8
      '{16'h0022, 8'h81, 8'hA5, 32'h81818181, 8'd6}, // R6 code 10
      '{16'h0032, 8'h5A, 8'hA5, 32'h5A5A5A5A, 8'd6}  // R6 code 11
   };

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic step(output logic ln, output logic tk);
      @(negedge clk);
      bit_en = 1'b1;
      #1 tk = take;
      @(negedge clk);
      bit_en = 1'b0;
      ln = line;
   endtask

   task automatic restart();
      logic ln, tk;
      logic [15:0] keep;
      keep = ctl;
      ctl = 16'h0000;
      step(ln, tk);
      chk("R1 mark when disabled", {31'd0, ln}, 32'd1);
      ctl = keep;
   endtask

   initial begin
      logic ln, tk;
      logic [31:0] stream;
      logic        any_take;
      repeat (3) @(negedge clk);
      chk("R1 reset line", {31'd0, line}, 32'd1);
      chk("R1 reset take", {31'd0, take}, 32'd0);
      rst_n = 1'b1;

      // table walk
      for (int i = 0; i < 8; i++) begin
         restart();
         ctl = VECS[i].ctl; lo = VECS[i].lo; hi = VECS[i].hi;
         stream = '0; any_take = 1'b0;
         for (int k = 0; k < 32; k++) begin
            step(ln, tk);
            stream[k] = ln;
            any_take |= tk;
         end
         chk($sformatf("R%0d pattern vector %0d", VECS[i].req, i), stream, VECS[i].exp);
         chk($sformatf("R%0d no take in idle", VECS[i].req), {31'd0, any_take}, 32'd0);
      end

      // R1: disabled with pulses
      ctl = 16'h0000; lo = 8'h00;
      stream = '0;
      for (int k = 0; k < 8; k++) begin step(ln, tk); stream[k] = ln; stream[8+k] = tk; end
      chk("R1 disabled stream", stream, 32'h000000FF);

      // R2: reset overrides enable, then fresh start
      ctl = 16'h0002; lo = 8'h01;
      step(ln, tk); step(ln, tk); step(ln, tk);
      ctl = 16'h0006;
      stream = '0;
      for (int k = 0; k < 8; k++) begin step(ln, tk); stream[k] = ln; end
      chk("R2 reset holds mark", stream, 32'h000000FF);
      ctl = 16'h0002;
      stream = '0;
      for (int k = 0; k < 8; k++) begin step(ln, tk); stream[k] = ln; end
      chk("R2 fresh pattern after reset", stream, 32'h00000001);

      // R7: change mid-pattern
      restart();
      ctl = 16'h0002; lo = 8'h0F;
      stream = '0;
      for (int k = 0; k < 3; k++) begin step(ln, tk); stream[k] = ln; end
      chk("R7 first bits", stream, 32'h00000007);
      lo = 8'hF0; ctl = 16'h0012; hi = 8'h00;
      stream = '0;
      for (int k = 0; k < 5; k++) begin step(ln, tk); stream[k] = ln; end
      chk("R7 old pattern completes", stream, 32'h00000001);
      ctl = 16'h0002;
      stream = '0;
      for (int k = 0; k < 8; k++) begin step(ln, tk); stream[k] = ln; end
      chk("R7 new pattern at boundary", stream, 32'h000000F0);

      // R9: line stable without bit enables
      restart();
      ctl = 16'h0002; lo = 8'h01;
      step(ln, tk);
      repeat (5) @(negedge clk);
      chk("R9 line holds without enable", {31'd0, line}, 32'd1);

      // R8: handover only at boundary
      restart();
      ctl = 16'h0002; lo = 8'h01;
      step(ln, tk); step(ln, tk);
      drdy = 1'b1; dbit = 1'b1;
      stream = '0; any_take = 1'b0;
      for (int k = 0; k < 6; k++) begin step(ln, tk); stream[k] = ln; any_take |= tk; end
      chk("R8 idle completes before data", stream, 32'h00000000);
      chk("R8 no take mid-pattern", {31'd0, any_take}, 32'd0);
      step(ln, tk);
      chk("R8 data bit 1 on line", {30'd0, tk, ln}, 32'd3);
      dbit = 1'b0;
      step(ln, tk);
      chk("R8 data bit 0 on line", {30'd0, tk, ln}, 32'd2);
      drdy = 1'b0;
      step(ln, tk);
      chk("R8 idle resumes", {30'd0, tk, ln}, 32'd1);

      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog expired actual=hung expected=finished");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end
endmodule